// File: doc/BRIEF.md
# Eight-Bit GPIO Port with Edge/Level Interrupts

This block is an eight-pin general-purpose I/O port that sits on a simple single-cycle register bus spanning a 4 KB window. Firmware picks each pin's direction and moves pin data through a data window. In that window, address bits [9:2] act as a per-bit mask on both reads and writes, so a single store can touch any subset of pins without a read-modify-write. Input pins pass through a synchronizer and are sampled into the data register every cycle. Output-direction pins drive the data register onto the pads. Input-direction pins drive a constant 1 with their output enable low.

Each pin can raise an interrupt on a rising edge, a falling edge, either edge, a high level or a low level. Pending bits are sticky until firmware clears them. The enabled pending bits are ORed onto one interrupt line. The alternate-function select register is guarded. A key written to the lock register opens the commit register, and only the bits set in the commit register can be changed in the alternate-function register. Eight pad-control registers are plain storage. A fixed identification table sits at the top of the window.

Top module: `gpio_port`

## Requirements
- R1: After reset every register reads 0, except these two: the lock register at 0x520 reads 1 and the commit register at 0x524 reads 0xFF. Out of reset, `pin_oe_o` is 0x00, `pin_o` is 0xFF and `irq_o` is 0.
- R2: A read at an offset below 0x400 returns the data register ANDed with address bits [9:2] in read bits [7:0]. All other read bits are zero.
- R3: A write below 0x400 updates data bit i only when address bit 2+i is 1 and direction bit i is 1. Every other data bit is left alone by the write.
- R4: The direction register is at 0x400, with bit value 1 meaning output. `pin_oe_o` equals the direction register. `pin_o[i]` is data bit i for an output pin and 1 for an input pin.
- R5: For input pins, the data register takes the pin level through a two-flop synchronizer. A change on `pin_i` between clock edges first appears in a data read after the third rising edge.
- R6: The interrupt configuration registers are sense at 0x404, both-edges at 0x408 and event at 0x40C. In edge mode (sense bit 0) the pending bit is set on either edge when the both-edges bit is 1. Otherwise it is set on a rising edge when the event bit is 1 and on a falling edge when the event bit is 0.
- R7: In level mode (sense bit 1) the pending bit is set every cycle that the synchronized pin equals the event bit; the both-edges bit is ignored. Pending bits are read at 0x414 and stay set until a write to 0x41C with a 1 in that bit position. If a set and a clear land on the same bit in the same cycle, the set wins.
- R8: The enable register is at 0x410. A read at 0x418 returns pending AND enable. `irq_o` is 1 exactly when that value is nonzero.
- R9: A write of 0x0ACCE551 to 0x520 unlocks the block, and a write of any other value to 0x520 locks it. The lock register reads 1 while locked and 0 while unlocked.
- R10: A write to the commit register at 0x524 takes effect only while the block is unlocked.
- R11: A write to the alternate-function register at 0x420 changes only the bits that are 1 in the commit register.
- R12: The eight pad registers at 0x500, 0x504, ..., 0x51C store bits [7:0] of a write and read them back.
- R13: Reads from 0xFD0 to 0xFFC return one identification byte per word. In word order the bytes are 00 00 00 00 61 00 18 01 0D F0 05 B1.
- R14: Unmapped offsets read as zero and ignore writes. The interrupt clear register at 0x41C also reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 12 | Byte offset within the register window |
| we_i | input | 1 | Write strobe; the write happens at the rising edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from `addr_i` |
| pin_i | input | 8 | External pin levels |
| pin_o | output | 8 | Pin output values |
| pin_oe_o | output | 8 | Pin output enables |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions assume that `pin_i` and the bus inputs are stable around each rising edge and that `addr_i` is word aligned. The bench changes every input on the falling edge and only uses offsets that are multiples of four. The edge-cause check also assumes the synchronizer starts from the reset level, so the bench holds all pins low through reset. Before it reads pending bits, the bench clears any status that was left behind while the configuration was being rewritten.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned PIN_W  = 8;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned PAD_N  = 8;
  localparam int unsigned ID_N   = 12;

  localparam logic [ADDR_W-1:0] OFF_DIR    = 12'h400;
  localparam logic [ADDR_W-1:0] OFF_SENSE  = 12'h404;
  localparam logic [ADDR_W-1:0] OFF_BOTH   = 12'h408;
  localparam logic [ADDR_W-1:0] OFF_EVENT  = 12'h40C;
  localparam logic [ADDR_W-1:0] OFF_IEN    = 12'h410;
  localparam logic [ADDR_W-1:0] OFF_RAW    = 12'h414;
  localparam logic [ADDR_W-1:0] OFF_MIS    = 12'h418;
  localparam logic [ADDR_W-1:0] OFF_ICLR   = 12'h41C;
  localparam logic [ADDR_W-1:0] OFF_ALTF   = 12'h420;
  localparam logic [ADDR_W-1:0] OFF_PAD    = 12'h500;
  localparam logic [ADDR_W-1:0] OFF_LOCK   = 12'h520;
  localparam logic [ADDR_W-1:0] OFF_COMMIT = 12'h524;
  localparam logic [ADDR_W-1:0] OFF_ID     = 12'hFD0;

  localparam logic [BUS_W-1:0] UNLOCK_KEY = 32'h0ACC_E551;

  typedef struct packed {
    logic [PIN_W-1:0] lvl_sel;
    logic [PIN_W-1:0] any_edge;
    logic [PIN_W-1:0] pol;
    logic [PIN_W-1:0] en;
  } irq_cfg_t;

  function automatic logic [7:0] id_byte(input logic [3:0] idx);
    case (idx)
      4'd4:    id_byte = 8'h61;
      4'd6:    id_byte = 8'h18;
      4'd7:    id_byte = 8'h01;
      4'd8:    id_byte = 8'h0D;
      4'd9:    id_byte = 8'hF0;
      4'd10:   id_byte = 8'h05;
      4'd11:   id_byte = 8'hB1;
      default: id_byte = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[s] <= '0;
        else         chain_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[s] <= '0;
        else         chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_pkg::*;
#(
  parameter int unsigned W = PIN_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] lvl_sel_i,
  input  logic [W-1:0] any_edge_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] en_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] raw_o,
  output logic [W-1:0] masked_o,
  output logic         irq_o
);
  logic [W-1:0] prev_q, raw_q, hit;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic rise, fall;
    assign rise   = lvl_i[i] & ~prev_q[i];
    assign fall   = ~lvl_i[i] & prev_q[i];
    assign hit[i] = lvl_sel_i[i]  ? (lvl_i[i] == pol_i[i]) :
                    any_edge_i[i] ? (rise | fall) :
                    pol_i[i]      ? rise : fall;

    // edge mode: a new pending bit needs a synchronized transition
    assert_edge_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!lvl_sel_i[i] && !raw_q[i]) |=> (!raw_q[i] || $past(lvl_i[i] ^ prev_q[i])));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      raw_q  <= '0;
    end else begin
      prev_q <= lvl_i;
      raw_q  <= (raw_q & ~clr_i) | hit;  // set beats clear
    end
  end

  assign raw_o    = raw_q;
  assign masked_o = raw_q & en_i;
  assign irq_o    = |masked_o;

  assert_raw_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(raw_q) & ~raw_q & ~$past(clr_i)) == '0));
endmodule

// File: rtl/gpio_lock.sv
module gpio_lock
  import gpio_pkg::*;
#(
  parameter int unsigned W = PIN_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_lock_i,
  input  logic             wr_commit_i,
  input  logic             wr_altf_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic             locked_o,
  output logic [W-1:0]     commit_o,
  output logic [W-1:0]     altf_o
);
  logic         locked_q;
  logic [W-1:0] commit_q, altf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b1;
      commit_q <= '1;
      altf_q   <= '0;
    end else begin
      if (wr_lock_i)                 locked_q <= (wdata_i != UNLOCK_KEY);
      if (wr_commit_i && !locked_q)  commit_q <= wdata_i[W-1:0];
      if (wr_altf_i)                 altf_q   <= (altf_q & ~commit_q) | (wdata_i[W-1:0] & commit_q);
    end
  end

  assign locked_o = locked_q;
  assign commit_o = commit_q;
  assign altf_o   = altf_q;

  assert_unlock_key_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_lock_i && wdata_i == UNLOCK_KEY) |=> !locked_o);
  assert_commit_guard_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |=> $stable(commit_o));
  assert_altf_guard_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (((altf_o ^ $past(altf_o)) & ~$past(commit_o)) == '0));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  input  logic [PIN_W-1:0]  pin_i,
  output logic [PIN_W-1:0]  pin_o,
  output logic [PIN_W-1:0]  pin_oe_o,
  output logic              irq_o
);
  localparam int unsigned PAD_IW = $clog2(PAD_N);

  logic [PIN_W-1:0] data_q, dir_q, pin_sync, win_mask;
  logic [PIN_W-1:0] raw, masked, commit, altf, clr_mask;
  logic [PIN_W-1:0] pad_q [PAD_N];
  irq_cfg_t         cfg_q;
  logic             locked;
  logic             in_data_win, in_pad_win, in_id_win;
  logic             wr_data;
  logic [PAD_IW-1:0] pad_idx;
  logic [ADDR_W-1:0] id_off;
  logic [ADDR_W-1:0] unused_id_off;

  assign in_data_win = (addr_i[ADDR_W-1:10] == '0);
  assign in_pad_win  = (addr_i[ADDR_W-1:5] == OFF_PAD[ADDR_W-1:5]);
  assign in_id_win   = (addr_i >= OFF_ID);
  assign win_mask    = addr_i[9:2];
  assign pad_idx     = addr_i[2 +: PAD_IW];
  assign id_off      = addr_i - OFF_ID;
  assign unused_id_off = id_off;
  assign wr_data     = we_i && in_data_win;
  assign clr_mask    = (we_i && addr_i == OFF_ICLR) ? wdata_i[PIN_W-1:0] : '0;

  gpio_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  // data: outputs take masked writes, inputs follow the synchronized pin
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
    end else begin
      for (int i = 0; i < PIN_W; i++) begin
        if (!dir_q[i])                     data_q[i] <= pin_sync[i];
        else if (wr_data && win_mask[i])   data_q[i] <= wdata_i[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '0;
      cfg_q <= '0;
    end else if (we_i) begin
      case (addr_i)
        OFF_DIR:   dir_q         <= wdata_i[PIN_W-1:0];
        OFF_SENSE: cfg_q.lvl_sel <= wdata_i[PIN_W-1:0];
        OFF_BOTH:  cfg_q.any_edge <= wdata_i[PIN_W-1:0];
        OFF_EVENT: cfg_q.pol     <= wdata_i[PIN_W-1:0];
        OFF_IEN:   cfg_q.en      <= wdata_i[PIN_W-1:0];
        default: ;
      endcase
    end
  end

  for (genvar p = 0; p < PAD_N; p++) begin : g_pad
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)                                       pad_q[p] <= '0;
      else if (we_i && in_pad_win && pad_idx == PAD_IW'(p)) pad_q[p] <= wdata_i[PIN_W-1:0];
  end

  gpio_irq_detect #(.W(PIN_W)) u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lvl_i     (pin_sync),
    .lvl_sel_i (cfg_q.lvl_sel),
    .any_edge_i(cfg_q.any_edge),
    .pol_i     (cfg_q.pol),
    .en_i      (cfg_q.en),
    .clr_i     (clr_mask),
    .raw_o     (raw),
    .masked_o  (masked),
    .irq_o     (irq_o)
  );

  gpio_lock #(.W(PIN_W)) u_lock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_lock_i  (we_i && addr_i == OFF_LOCK),
    .wr_commit_i(we_i && addr_i == OFF_COMMIT),
    .wr_altf_i  (we_i && addr_i == OFF_ALTF),
    .wdata_i    (wdata_i),
    .locked_o   (locked),
    .commit_o   (commit),
    .altf_o     (altf)
  );

  always_comb begin
    rdata_o = '0;
    if (in_data_win) begin
      rdata_o[PIN_W-1:0] = data_q & win_mask;
    end else if (in_id_win) begin
      rdata_o[7:0] = id_byte(id_off[5:2]);
    end else if (in_pad_win) begin
      rdata_o[PIN_W-1:0] = pad_q[pad_idx];
    end else begin
      case (addr_i)
        OFF_DIR:    rdata_o[PIN_W-1:0] = dir_q;
        OFF_SENSE:  rdata_o[PIN_W-1:0] = cfg_q.lvl_sel;
        OFF_BOTH:   rdata_o[PIN_W-1:0] = cfg_q.any_edge;
        OFF_EVENT:  rdata_o[PIN_W-1:0] = cfg_q.pol;
        OFF_IEN:    rdata_o[PIN_W-1:0] = cfg_q.en;
        OFF_RAW:    rdata_o[PIN_W-1:0] = raw;
        OFF_MIS:    rdata_o[PIN_W-1:0] = masked;
        OFF_ALTF:   rdata_o[PIN_W-1:0] = altf;
        OFF_LOCK:   rdata_o[0]         = locked;
        OFF_COMMIT: rdata_o[PIN_W-1:0] = commit;
        default: ;
      endcase
    end
  end

  assign pin_oe_o = dir_q;
  assign pin_o    = (data_q & dir_q) | ~dir_q;

  assert_data_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_data |=> (((data_q ^ $past(data_q)) & $past(dir_q)) == '0));
  assert_unmasked_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_data |=> (((data_q ^ $past(data_q)) & $past(dir_q) & ~$past(win_mask)) == '0));
  assert_idle_pin_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pin_o | pin_oe_o) == '1));
endmodule

// File: tb/tb_gpio_port.sv
`timescale 1ns/1ps
module tb_gpio_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  pin = '0;
  logic [7:0]  pin_o, pin_oe;
  logic        irq;
  int          nvec = 0;
  int          nerr = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  gpio_port dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pin_i(pin), .pin_o(pin_o), .pin_oe_o(pin_oe), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [7:0]  md, dir, pv, exp8, cm, af;
    logic [7:0]  ids [12];
    logic [7:0]  dirs [4];
    ids = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h61, 8'h00, 8'h18, 8'h01, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    dirs = '{8'h00, 8'hF0, 8'h3C, 8'hFF};

    cyc(3);
    rst_n = 1'b1;
    cyc(2);

    // R1 reset state
    rd(12'h520, r); chk("R1 lock", r, 32'h1);
    rd(12'h524, r); chk("R1 commit", r, 32'hFF);
    foreach (dirs[k]) begin end
    for (int a = 12'h400; a <= 12'h420; a += 4) begin
      rd(12'(a), r); chk("R1 regs zero", r, 32'h0);
    end
    for (int a = 12'h500; a <= 12'h51C; a += 4) begin
      rd(12'(a), r); chk("R1 pad zero", r, 32'h0);
    end
    chk("R1 oe", {24'h0, pin_oe}, 32'h00);
    chk("R1 pin_o", {24'h0, pin_o}, 32'hFF);
    chk("R1 irq", {31'h0, irq}, 32'h0);

    // R5 synchronizer latency
    @(negedge clk); pin = 8'h81;
    cyc(2); rd(12'h3FC, r); chk("R5 before third edge", r, 32'h00);
    cyc(1); rd(12'h3FC, r); chk("R5 after third edge", r, 32'h81);

    // R2 R3 R4 sweep over directions and masks
    pv = 8'h5A;
    @(negedge clk); pin = pv;
    cyc(4);
    md = pv; dir = 8'h00;
    foreach (dirs[k]) begin
      md = (md & dir) | (pv & ~dir);
      dir = dirs[k];
      wr(12'h400, {24'h0, dir});
      rd(12'h400, r); chk("R4 dir readback", r, {24'h0, dir});
      for (int m = 0; m < 256; m++) begin
        logic [7:0] wd, wm;
        wd = 8'(m * 37) ^ 8'hC3;
        wm = 8'(m) & dir;
        wr({2'b00, 8'(m), 2'b00}, {24'hFFFFFF, wd});
        md = (md & ~wm) | (wd & wm);
        exp8 = (md & dir) | (pv & ~dir);
        rd(12'h3FC, r); chk("R3 masked write", r, {24'h0, exp8});
        chk("R4 pin_o", {24'h0, pin_o}, {24'h0, (md & dir) | ~dir});
        chk("R4 pin_oe", {24'h0, pin_oe}, {24'h0, dir});
      end
      exp8 = (md & dir) | (pv & ~dir);
      for (int m = 0; m < 256; m++) begin
        rd({2'b00, 8'(m), 2'b00}, r); chk("R2 masked read", r, {24'h0, exp8 & 8'(m)});
      end
    end

    // R6 R7 R8 interrupt configurations
    wr(12'h400, 32'h0);
    for (int c = 0; c < 8; c++) begin
      bit sn, be, ev;
      logic [7:0] e;
      sn = c[2]; be = c[1]; ev = c[0];
      @(negedge clk); pin = 8'h00;
      cyc(5);
      wr(12'h404, sn ? 32'hFF : 32'h0);
      wr(12'h408, be ? 32'hFF : 32'h0);
      wr(12'h40C, ev ? 32'hFF : 32'h0);
      wr(12'h410, 32'h05);
      wr(12'h41C, 32'hFF);
      cyc(2);
      e = (sn && !ev) ? 8'hFF : 8'h00;
      rd(12'h414, r); chk("R7 steady low", r, {24'h0, e});
      rd(12'h418, r); chk("R8 masked", r, {24'h0, e & 8'h05});
      chk("R8 irq", {31'h0, irq}, {31'h0, |(e & 8'h05)});

      @(negedge clk); pin = 8'h0F;
      cyc(5);
      e = sn ? (ev ? 8'h0F : 8'hFF) : ((be || ev) ? 8'h0F : 8'h00);
      rd(12'h414, r); chk(sn ? "R7 level rise" : "R6 rising", r, {24'h0, e});
      rd(12'h418, r); chk("R8 masked", r, {24'h0, e & 8'h05});
      chk("R8 irq", {31'h0, irq}, {31'h0, |(e & 8'h05)});
      wr(12'h41C, 32'hFF);
      cyc(2);
      e = sn ? (ev ? 8'h0F : 8'hF0) : 8'h00;
      rd(12'h414, r); chk("R7 clear vs level", r, {24'h0, e});

      @(negedge clk); pin = 8'h00;
      cyc(5);
      e = sn ? (ev ? 8'h0F : 8'hFF) : ((be || !ev) ? 8'h0F : 8'h00);
      rd(12'h414, r); chk(sn ? "R7 level fall" : "R6 falling", r, {24'h0, e});
      rd(12'h418, r); chk("R8 masked", r, {24'h0, e & 8'h05});
      chk("R8 irq", {31'h0, irq}, {31'h0, |(e & 8'h05)});
    end
    wr(12'h404, 32'h0); wr(12'h40C, 32'h0); wr(12'h408, 32'h0);
    wr(12'h41C, 32'hFF);
    wr(12'h41C, 32'h02);  // partial clear after everything cleared
    rd(12'h414, r); chk("R7 cleared", r, 32'h0);

    // R9 R10 R11 lock, commit, alternate function
    af = 8'h00; cm = 8'hFF;
    wr(12'h420, 32'hA5); af = 8'hA5;
    rd(12'h420, r); chk("R11 full commit", r, {24'h0, af});
    wr(12'h524, 32'h0F);
    rd(12'h524, r); chk("R10 locked commit", r, {24'h0, cm});
    wr(12'h520, 32'h0ACCE551);
    rd(12'h520, r); chk("R9 unlocked", r, 32'h0);
    wr(12'h524, 32'h0F); cm = 8'h0F;
    rd(12'h524, r); chk("R10 unlocked commit", r, {24'h0, cm});
    wr(12'h520, 32'h0ACCE550);
    rd(12'h520, r); chk("R9 relocked", r, 32'h1);
    wr(12'h524, 32'h33);
    rd(12'h524, r); chk("R10 relocked commit", r, {24'h0, cm});
    for (int v = 0; v < 256; v++) begin
      wr(12'h420, 32'(v));
      af = (af & ~cm) | (8'(v) & cm);
      rd(12'h420, r); chk("R11 commit mask", r, {24'h0, af});
    end
    wr(12'h520, 32'h0ACCE551);
    wr(12'h524, 32'hC3); cm = 8'hC3;
    wr(12'h520, 32'h1);
    wr(12'h420, 32'h3C); af = (af & ~cm) | (8'h3C & cm);
    rd(12'h420, r); chk("R11 new commit", r, {24'h0, af});

    // R12 pad storage
    for (int p = 0; p < 8; p++)
      wr(12'(12'h500 + 4 * p), 32'hFFFFFF00 | 32'(8'(p * 29) ^ 8'hA5));
    for (int p = 0; p < 8; p++) begin
      rd(12'(12'h500 + 4 * p), r);
      chk("R12 pad readback", r, {24'h0, 8'(p * 29) ^ 8'hA5});
    end

    // R13 identification
    for (int i = 0; i < 12; i++) begin
      rd(12'(12'hFD0 + 4 * i), r); chk("R13 id byte", r, {24'h0, ids[i]});
    end

    // R14 unmapped
    rd(12'h400, r); dir = r[7:0];
    wr(12'h424, 32'hFF); wr(12'h600, 32'hFF); wr(12'hFD0, 32'hFF); wr(12'h414, 32'hFF);
    rd(12'h424, r); chk("R14 unmapped read", r, 32'h0);
    rd(12'h7FC, r); chk("R14 unmapped read", r, 32'h0);
    rd(12'hFCC, r); chk("R14 unmapped read", r, 32'h0);
    rd(12'h41C, r); chk("R14 clear reads zero", r, 32'h0);
    rd(12'hFD0, r); chk("R14 id unchanged", r, 32'h0);
    rd(12'h414, r); chk("R14 raw unchanged", r, 32'h0);
    rd(12'h400, r); chk("R14 dir unchanged", r, {24'h0, dir});
    rd(12'h420, r); chk("R14 altf unchanged", r, {24'h0, af});

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule